// File: doc/BRIEF.md
# Framed Serial Character Link (Receive Checker and Transmit Framer)

This block sits behind a demodulator and turns a stream of received bits into checked command bytes. Bits arrive one at a time, each marked by a strobe. Separate one-cycle inputs mark the start and the end of a frame. The receiver groups the bits into 10-bit characters and stores every character's byte. When the end marker arrives, it checks a 16-bit CRC that closes the frame. Only a frame that passes every check is released downstream. The frame is dropped silently when the CRC is wrong, when a character is malformed, when the frame is too short or too long, or when the device is not selected and the frame is not a select command. No error indication exists.

A released frame appears as a burst of data bytes, one per clock cycle, with a frame-good pulse and a byte count on the last byte. The companion transmit framer takes response bytes through a ready/valid handshake. It emits a start marker, serializes each byte as a character, and appends the two CRC characters and an end marker. A transmitted frame is therefore directly readable by the receiver.

Top module: `char_frame_link`

## Requirements
- R1: A character is 10 bits, sent one per strobe: a 0 start bit, then 8 data bits least significant first, then a 1 stop bit. A 1 in the start position or a 0 in the stop position aborts the frame, and that frame produces no output.
- R2: A valid frame is a start marker, at least one data character, two CRC characters and an end marker. A frame with fewer than three characters is dropped. A frame whose end marker falls inside a character is also dropped.
- R3: The CRC is computed over the data bytes only. It processes each byte least significant bit first, uses the reflected form 0x8408 of polynomial 0x1021, starts from 0xFFFF and is inverted at the end. The low byte travels first. Any mismatch drops the frame with no output.
- R4: For a valid frame, the data bytes appear on `out_byte` with `out_vld` high, in arrival order, one per consecutive cycle. The first byte appears in the cycle after the end marker is sampled. CRC bytes are never output.
- R5: `out_good` is high for exactly one cycle, together with the last data byte. In that cycle `out_count` equals the number of data bytes.
- R6: While `dev_sel` is low, a frame is passed only if its first data byte equals the select opcode (parameter `SEL_CMD`, default 0x6C). Any other frame is dropped.
- R7: A start marker inside a frame discards everything collected so far and starts a new frame.
- R8: A frame may carry at most `MAX_DATA` data bytes (default 8). A frame with exactly `MAX_DATA` data bytes passes. A frame with one more is dropped.
- R9: After reset, `out_vld`, `out_good`, `tx_sof`, `tx_eof`, `tx_bit_vld` and `tx_ready` are low.
- R10: When `tx_vld` is seen while the framer is idle, `tx_sof` pulses for one cycle and then `tx_ready` rises. Each byte accepted on `tx_ready && tx_vld` is sent as a character in the R1 format, with one bit per cycle and `tx_bit_vld` high.
- R11: After the character of the byte flagged `tx_last`, the framer sends the R3 CRC as two characters, low byte first. It then raises `tx_eof` for one cycle and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_vld | input | 1 | Strobe: `rx_bit` holds a new bit |
| rx_sof | input | 1 | Start-of-frame marker |
| rx_eof | input | 1 | End-of-frame marker |
| dev_sel | input | 1 | Device is currently selected |
| out_byte | output | 8 | Released data byte |
| out_vld | output | 1 | `out_byte` is valid |
| out_good | output | 1 | Last byte of a checked frame |
| out_count | output | CW | Data byte count, valid with `out_good` |
| tx_byte | input | 8 | Response byte to send |
| tx_vld | input | 1 | `tx_byte` is offered |
| tx_last | input | 1 | Offered byte is the last data byte |
| tx_ready | output | 1 | Framer accepts a byte this cycle |
| tx_bit | output | 1 | Transmitted serial bit |
| tx_bit_vld | output | 1 | `tx_bit` carries a bit |
| tx_sof | output | 1 | Transmit start-of-frame marker |
| tx_eof | output | 1 | Transmit end-of-frame marker |

## Verification
A corrupted receive state shows up as a missing, extra or shifted byte burst. It can also show as a wrong count, seen a few cycles after the end marker. A CRC register that is one byte out of step rejects every good frame, and the first loopback frame exposes it. The bench flips every bit of a short frame one at a time to confirm that no single error passes. It also decodes the transmit line on its own and compares it against CRC values computed in the bench, so a fault shared by both directions cannot cancel out in loopback.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

    // One byte folded into the running CRC, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in, input logic [7:0] data);
        logic [15:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/cfl_rx.sv
module cfl_rx
    import cfl_pkg::*;
#(
    parameter int MAX_DATA = 8,
    parameter logic [7:0] SEL_CMD = 8'h6C,
    localparam int DEPTH = MAX_DATA + 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_bit,
    input  logic          rx_bit_vld,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          dev_sel,
    output logic [7:0]    out_byte,
    output logic          out_vld,
    output logic          out_good,
    output logic [CW-1:0] out_count
);

    typedef enum logic [1:0] {RX_IDLE, RX_COLL, RX_PLAY} rx_st_e;

    typedef struct packed {
        rx_st_e                st;
        logic [3:0]            idx;
        logic [7:0]            sh;
        logic [CW-1:0]         cnt;
        logic [CW-1:0]         rd;
        logic [15:0]           crc;
        logic [7:0]            h0;
        logic [7:0]            h1;
        logic [DEPTH-1:0][7:0] mem;
    } rx_s;

    rx_s q, d;
    logic crc_ok, gate_ok;

    always_comb begin
        d         = q;
        out_vld   = 1'b0;
        out_good  = 1'b0;
        out_byte  = q.mem[q.rd];
        out_count = q.cnt - CW'(2);
        crc_ok    = (~q.crc) == {q.h0, q.h1};
        gate_ok   = dev_sel || (q.mem[0] == SEL_CMD);
        case (q.st)
            RX_IDLE: begin
                if (rx_sof) begin
                    d.st  = RX_COLL;
                    d.idx = 4'd0;
                    d.cnt = '0;
                    d.crc = CRC_SEED;
                end
            end
            RX_COLL: begin
                if (rx_sof) begin
                    d.idx = 4'd0;
                    d.cnt = '0;
                    d.crc = CRC_SEED;
                end else if (rx_eof) begin
                    if (q.idx == 4'd0 && q.cnt >= CW'(3) && crc_ok && gate_ok) begin
                        d.st = RX_PLAY;
                        d.rd = '0;
                    end else begin
                        d.st = RX_IDLE;
                    end
                end else if (rx_bit_vld) begin
                    if (q.idx == 4'd0) begin
                        if (rx_bit) d.st = RX_IDLE;
                        else        d.idx = 4'd1;
                    end else if (q.idx == 4'd9) begin
                        if (!rx_bit || q.cnt == CW'(DEPTH)) begin
                            d.st = RX_IDLE;
                        end else begin
                            d.mem[q.cnt] = q.sh;
                            d.cnt        = q.cnt + CW'(1);
                            d.h0         = q.sh;
                            d.h1         = q.h0;
                            // the byte two behind the newest is known to be data
                            if (q.cnt >= CW'(2)) d.crc = crc16_step(q.crc, q.h1);
                            d.idx = 4'd0;
                        end
                    end else begin
                        d.sh  = {rx_bit, q.sh[7:1]};
                        d.idx = q.idx + 4'd1;
                    end
                end
            end
            RX_PLAY: begin
                out_vld = 1'b1;
                if (q.rd == q.cnt - CW'(3)) begin
                    out_good = 1'b1;
                    d.st     = RX_IDLE;
                end else begin
                    d.rd = q.rd + CW'(1);
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_burst_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(rx_eof));
    assert_burst_unbroken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_good) |=> out_vld);
    assert_burst_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_good |=> !out_vld);
    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_good |-> (out_count >= CW'(1) && out_count <= CW'(MAX_DATA)));

endmodule

// File: rtl/cfl_tx.sv
module cfl_tx
    import cfl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_byte,
    input  logic       tx_vld,
    input  logic       tx_last,
    output logic       tx_ready,
    output logic       tx_bit,
    output logic       tx_bit_vld,
    output logic       tx_sof,
    output logic       tx_eof
);

    typedef enum logic [2:0] {TX_IDLE, TX_SOF, TX_LOAD, TX_SEND, TX_EOF} tx_st_e;

    typedef struct packed {
        tx_st_e      st;
        logic [3:0]  idx;
        logic [7:0]  sh;
        logic [15:0] crc;
        logic [1:0]  ph;
        logic        last;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d          = q;
        tx_ready   = 1'b0;
        tx_bit     = 1'b0;
        tx_bit_vld = 1'b0;
        tx_sof     = 1'b0;
        tx_eof     = 1'b0;
        case (q.st)
            TX_IDLE: begin
                if (tx_vld) begin
                    d.st  = TX_SOF;
                    d.crc = CRC_SEED;
                end
            end
            TX_SOF: begin
                tx_sof = 1'b1;
                d.st   = TX_LOAD;
            end
            TX_LOAD: begin
                tx_ready = 1'b1;
                if (tx_vld) begin
                    d.st   = TX_SEND;
                    d.sh   = tx_byte;
                    d.last = tx_last;
                    d.crc  = crc16_step(q.crc, tx_byte);
                    d.idx  = 4'd0;
                    d.ph   = 2'd0;
                end
            end
            TX_SEND: begin
                tx_bit_vld = 1'b1;
                if (q.idx == 4'd0)      tx_bit = 1'b0;
                else if (q.idx == 4'd9) tx_bit = 1'b1;
                else                    tx_bit = q.sh[q.idx[2:0] - 3'd1];
                if (q.idx == 4'd9) begin
                    d.idx = 4'd0;
                    case (q.ph)
                        2'd0: begin
                            if (q.last) begin
                                d.ph = 2'd1;
                                d.sh = ~q.crc[7:0];
                            end else begin
                                d.st = TX_LOAD;
                            end
                        end
                        2'd1: begin
                            d.ph = 2'd2;
                            d.sh = ~q.crc[15:8];
                        end
                        default: d.st = TX_EOF;
                    endcase
                end else begin
                    d.idx = q.idx + 4'd1;
                end
            end
            TX_EOF: begin
                tx_eof = 1'b1;
                d.st   = TX_IDLE;
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_load_after_sof_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |=> tx_ready);
    assert_start_bit_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_vld) |=> (tx_bit_vld && !tx_bit));
    assert_bits_end_cleanly_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_bit_vld) |-> (tx_ready || tx_eof));
    assert_eof_then_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |=> (!tx_bit_vld && !tx_ready));

endmodule

// File: rtl/char_frame_link.sv
module char_frame_link #(
    parameter int MAX_DATA = 8,
    parameter logic [7:0] SEL_CMD = 8'h6C,
    localparam int CW = $clog2(MAX_DATA + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_bit,
    input  logic          rx_bit_vld,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          dev_sel,
    output logic [7:0]    out_byte,
    output logic          out_vld,
    output logic          out_good,
    output logic [CW-1:0] out_count,
    input  logic [7:0]    tx_byte,
    input  logic          tx_vld,
    input  logic          tx_last,
    output logic          tx_ready,
    output logic          tx_bit,
    output logic          tx_bit_vld,
    output logic          tx_sof,
    output logic          tx_eof
);

    cfl_rx #(.MAX_DATA(MAX_DATA), .SEL_CMD(SEL_CMD)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .dev_sel(dev_sel),
        .out_byte(out_byte), .out_vld(out_vld), .out_good(out_good), .out_count(out_count)
    );

    cfl_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .tx_byte(tx_byte), .tx_vld(tx_vld), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_bit(tx_bit), .tx_bit_vld(tx_bit_vld), .tx_sof(tx_sof), .tx_eof(tx_eof)
    );

endmodule

// File: tb/char_frame_link_test.sv
`timescale 1ns/1ps
module char_frame_link_test;
    localparam int MAXD = 8;
    localparam logic [7:0] SELC = 8'h6C;
    localparam int CW = $clog2(MAXD + 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic lb = 1'b0;
    logic d_bit = 1'b0, d_vld = 1'b0, d_sof = 1'b0, d_eof = 1'b0;
    logic dev_sel = 1'b1;
    logic rx_bit, rx_bit_vld, rx_sof, rx_eof;
    logic [7:0] out_byte;
    logic out_vld, out_good;
    logic [CW-1:0] out_count;
    logic [7:0] tx_byte = 8'h00;
    logic tx_vld = 1'b0, tx_last = 1'b0;
    logic tx_ready, tx_bit, tx_bit_vld, tx_sof, tx_eof;

    assign rx_bit     = lb ? tx_bit     : d_bit;
    assign rx_bit_vld = lb ? tx_bit_vld : d_vld;
    assign rx_sof     = lb ? tx_sof     : d_sof;
    assign rx_eof     = lb ? tx_eof     : d_eof;

    char_frame_link #(.MAX_DATA(MAXD), .SEL_CMD(SELC)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .dev_sel(dev_sel),
        .out_byte(out_byte), .out_vld(out_vld), .out_good(out_good), .out_count(out_count),
        .tx_byte(tx_byte), .tx_vld(tx_vld), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_bit(tx_bit), .tx_bit_vld(tx_bit_vld), .tx_sof(tx_sof), .tx_eof(tx_eof)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] fb [16];
    logic [7:0] cap [32];
    int ncap = 0, ngood = 0, gcount = 0;
    logic [7:0] tcap [16];
    logic [9:0] tsh;
    int tcn = 0, tbit = 0, tbad = 0, teof = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (out_vld) begin
            if (ncap < 32) cap[ncap] = out_byte;
            ncap++;
        end
        if (out_good) begin
            ngood++;
            gcount = int'(out_count);
        end
        if (tx_sof) begin
            tcn = 0; tbit = 0; tbad = 0;
        end
        if (tx_bit_vld) begin
            tsh[tbit] = tx_bit;
            tbit++;
            if (tbit == 10) begin
                if (tsh[0] != 1'b0 || tsh[9] != 1'b1) tbad++;
                if (tcn < 16) tcap[tcn] = tsh[8:1];
                tcn++;
                tbit = 0;
            end
        end
        if (tx_eof) teof++;
    end

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++)
                if (c[0] ^ fb[i][j]) c = (c >> 1) ^ 16'h8408;
                else                 c = c >> 1;
        return ~c;
    endfunction

    task automatic seal(input int n);
        logic [15:0] c = ref_crc(n);
        fb[n]     = c[7:0];
        fb[n + 1] = c[15:8];
    endtask

    task automatic clr();
        ncap = 0; ngood = 0; gcount = 0;
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    task automatic drv_bit(input logic b);
        d_bit = b; d_vld = 1'b1;
        @(negedge clk);
        d_vld = 1'b0;
    endtask

    task automatic drv_char(input logic [7:0] v, input logic st, input logic sp);
        drv_bit(st);
        for (int j = 0; j < 8; j++) drv_bit(v[j]);
        drv_bit(sp);
    endtask

    task automatic drv_sof();
        d_sof = 1'b1; @(negedge clk); d_sof = 1'b0;
    endtask

    task automatic drv_eof();
        d_eof = 1'b1; @(negedge clk); d_eof = 1'b0;
    endtask

    task automatic drv_frame(input int nch, input int bad_start, input int bad_stop);
        drv_sof();
        for (int i = 0; i < nch; i++) drv_char(fb[i], i == bad_start, i != bad_stop);
        drv_eof();
    endtask

    task automatic send_tx(input int n);
        for (int k = 0; k < n; k++) begin
            tx_byte = fb[k]; tx_last = (k == n - 1); tx_vld = 1'b1;
            forever begin
                @(negedge clk);
                if (tx_ready) break;
            end
            @(negedge clk);
        end
        tx_vld = 1'b0; tx_last = 1'b0;
    endtask

    task automatic expect_pass(input string req, input int n);
        chk({req, " good pulse"}, ngood, 1);
        chk({req, " count"}, gcount, n);
        chk({req, " burst length"}, ncap, n);
        for (int i = 0; i < n && i < 32; i++) chk({req, " byte"}, int'(cap[i]), int'(fb[i]));
    endtask

    task automatic expect_drop(input string req);
        chk({req, " dropped"}, ncap + ngood, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: quiet outputs after reset
        chk("R9 out_vld", int'(out_vld), 0);
        chk("R9 out_good", int'(out_good), 0);
        chk("R9 tx_sof", int'(tx_sof), 0);
        chk("R9 tx_eof", int'(tx_eof), 0);
        chk("R9 tx_bit_vld", int'(tx_bit_vld), 0);
        chk("R9 tx_ready", int'(tx_ready), 0);

        // R10 R11 R3 R4 R5: loopback sweep over every length and three patterns
        lb = 1'b1;
        for (int p = 0; p < 3; p++) begin
            for (int n = 1; n <= MAXD; n++) begin
                for (int i = 0; i < n; i++) fb[i] = 8'((i * 37 + n * 11 + p * 73 + p * p * 5) & 8'hFF);
                seal(n);
                clr(); teof = 0;
                send_tx(n);
                settle();
                chk("R11 eof pulses", teof, 1);
                chk("R10 char count", tcn, n + 2);
                chk("R1 tx start/stop bits", tbad, 0);
                for (int i = 0; i < n + 2; i++) chk("R10 R11 tx byte", int'(tcap[i]), int'(fb[i]));
                expect_pass("R4 R5 loopback", n);
            end
        end
        lb = 1'b0;
        @(negedge clk);

        // R3: direct good frame
        fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33; seal(3);
        clr(); drv_frame(5, -1, -1); settle();
        expect_pass("R3 direct good", 3);

        // R3: every single-bit error, data and CRC alike, is dropped
        for (int b = 0; b < 40; b++) begin
            fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33; seal(3);
            fb[b / 8][b % 8] = ~fb[b / 8][b % 8];
            clr(); drv_frame(5, -1, -1); settle();
            expect_drop("R3 bit flip");
        end

        // R1: malformed start and stop bits
        fb[0] = 8'hA1; fb[1] = 8'h5E; fb[2] = 8'h07; seal(3);
        clr(); drv_frame(5, 1, -1); settle();
        expect_drop("R1 bad start");
        clr(); drv_frame(5, -1, 2); settle();
        expect_drop("R1 bad stop");

        // R2: CRC only, no data character
        fb[0] = 8'h00; fb[1] = 8'h00;
        clr(); drv_frame(2, -1, -1); settle();
        expect_drop("R2 too short");

        // R2: end marker inside a character
        fb[0] = 8'h42; fb[1] = 8'h24; fb[2] = 8'h99; seal(3);
        clr(); drv_sof();
        for (int i = 0; i < 5; i++) drv_char(fb[i], 1'b0, 1'b1);
        drv_bit(1'b0); drv_eof(); settle();
        expect_drop("R2 eof mid char");

        // R6: selection gate
        dev_sel = 1'b0;
        fb[0] = 8'h12; fb[1] = 8'h34; seal(2);
        clr(); drv_frame(4, -1, -1); settle();
        expect_drop("R6 unselected other");
        fb[0] = SELC; fb[1] = 8'h34; seal(2);
        clr(); drv_frame(4, -1, -1); settle();
        expect_pass("R6 unselected select", 2);
        dev_sel = 1'b1;

        // R7: restart on a start marker inside a frame
        clr(); drv_sof();
        drv_char(8'hAA, 1'b0, 1'b1); drv_char(8'h55, 1'b0, 1'b1);
        drv_bit(1'b0); drv_bit(1'b1);
        fb[0] = 8'hC3; fb[1] = 8'h3C; seal(2);
        drv_frame(4, -1, -1); settle();
        expect_pass("R7 restart", 2);

        // R8: capacity boundary
        for (int i = 0; i < MAXD + 1; i++) fb[i] = 8'(i * 29 + 3);
        seal(MAXD + 1);
        clr(); drv_frame(MAXD + 3, -1, -1); settle();
        expect_drop("R8 overflow");
        for (int i = 0; i < MAXD; i++) fb[i] = 8'(i * 29 + 3);
        seal(MAXD);
        clr(); drv_frame(MAXD + 2, -1, -1); settle();
        expect_pass("R8 full", MAXD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule